// File: doc/BRIEF.md
# Vector Lane Element Sequencer

The sequencer steps one vector instruction at a time through a bank of parallel lanes. A vector register holds `VLEN` elements (32 by default). `LANES` lanes (8, 16 or 32) handle one element group per cycle, so an instruction takes `VLEN/LANES` groups. The groups enter the read stage in ascending order, one per cycle. Each group then passes through the execute stage of its functional unit and is written back. The ALU executes in a single stage. The load/store unit has a fully pipelined four-stage execute.

A start request names the unit and says whether the new instruction depends on the instruction accepted just before it. A mode input picks how that dependency is resolved:

- In the no-chaining mode, reading waits until the producer has written back every group.
- In the flexible-chaining mode, group k may be read in the same cycle that the producer writes back its group k, or in any later cycle.

The block reports the group index in the read, execute and write-back stages every cycle, and a per-unit done pulse. Storage, memory and the scalar pipeline live elsewhere.

Top module: `vlane_seq`

## Requirements
- R1: An instruction has NGRP = VLEN/LANES groups. Reads proceed one group per cycle in ascending order 0..NGRP-1 on `rd_vld_o`/`rd_grp_o`. Group 0 is read in the cycle after acceptance unless a dependency holds it.
- R2: For the ALU (`unit_i`=0, vector index 0), a group read in cycle c shows on `ex_vld_o[0]` in cycle c+1 and on `wb_vld_o[0]` in cycle c+2, carrying the same group index.
- R3: For the load/store unit (`unit_i`=1, vector index 1), a group read in cycle c enters the first execute stage (`ex_vld_o[1]`) in cycle c+1 and is written back (`wb_vld_o[1]`) in cycle c+5.
- R4: `done_o[u]` is high exactly in the cycle that group NGRP-1 of an instruction is written back on unit u.
- R5: `ready_o` is high only when no instruction is being read and the unit selected by `unit_i` is free. A unit is busy from acceptance until its last group leaves the final execute stage, so it is free again in the cycle of that last write-back. A start while `ready_o` is low is ignored.
- R6: With `dep_i`=1 and `chain_i`=0, group 0 is read no earlier than the cycle after the producer's last write-back.
- R7: With `dep_i`=1 and `chain_i`=1, group k is read no earlier than the cycle in which the producer writes back group k, and the same cycle is allowed.
- R8: With `dep_i`=0, reading is never held by the previous instruction.
- R9: Write-backs on the two units may fall in the same cycle, and both are reported on their own ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to start a vector instruction |
| unit_i | input | 1 | Functional unit: 0 ALU, 1 load/store |
| dep_i | input | 1 | Instruction depends on the previous instruction |
| chain_i | input | 1 | 1 flexible chaining, 0 no chaining |
| ready_o | output | 1 | Start would be accepted this cycle |
| rd_vld_o | output | 1 | A group is read this cycle |
| rd_grp_o | output | GW | Group index being read |
| ex_vld_o | output | 2 | Group in first execute stage, per unit |
| ex_grp_o | output | 2*GW | Group index in first execute stage, unit u at bits [u*GW +: GW] |
| wb_vld_o | output | 2 | Group written back, per unit |
| wb_grp_o | output | 2*GW | Group index written back, unit u at bits [u*GW +: GW] |
| done_o | output | 2 | Last group written back, per unit |

## Verification
Two functions meet in one cycle under flexible chaining. A dependent ALU instruction is started right after a load/store producer finishes reading. The consumer's read of group k then lands in the same cycle as the producer's write-back of group k, and later the ALU and load/store write-backs overlap. The bench logs every cycle and judges the exact cycles of each read, write-back and done pulse. Any off-by-one in the same-cycle chaining rule shifts the consumer's whole schedule by a cycle and is reported.

// File: rtl/vls_pkg.sv
package vls_pkg;
  localparam int NUM_UNITS = 2;
  typedef enum logic {UNIT_ALU = 1'b0, UNIT_LSU = 1'b1} unit_e;
  typedef logic [1:0] tag_t;

  function automatic int unit_depth(int u, int alu_d, int lsu_d);
    return (u == int'(UNIT_ALU)) ? alu_d : lsu_d;
  endfunction
endpackage

// File: rtl/vls_unit_pipe.sv
module vls_unit_pipe
  import vls_pkg::*;
#(
  parameter int DEPTH = 1,
  parameter int GW    = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acq_i,
  input  logic          in_vld_i,
  input  logic [GW-1:0] in_grp_i,
  input  tag_t          in_tag_i,
  input  logic          in_last_i,
  output logic          ex_vld_o,
  output logic [GW-1:0] ex_grp_o,
  output logic          wb_vld_o,
  output logic [GW-1:0] wb_grp_o,
  output tag_t          wb_tag_o,
  output logic          done_o,
  output logic          busy_o
);
  logic [DEPTH-1:0]         s_vld;
  logic [DEPTH-1:0]         s_last;
  logic [DEPTH-1:0][GW-1:0] s_grp;
  tag_t [DEPTH-1:0]         s_tag;
  logic                     wb_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_vld    <= '0;
      s_last   <= '0;
      s_grp    <= '0;
      s_tag    <= '0;
      wb_vld_o <= 1'b0;
      wb_last  <= 1'b0;
      wb_grp_o <= '0;
      wb_tag_o <= '0;
      busy_o   <= 1'b0;
    end else begin
      s_vld[0]  <= in_vld_i;
      s_last[0] <= in_last_i;
      s_grp[0]  <= in_grp_i;
      s_tag[0]  <= in_tag_i;
      for (int i = 1; i < DEPTH; i++) begin
        s_vld[i]  <= s_vld[i-1];
        s_last[i] <= s_last[i-1];
        s_grp[i]  <= s_grp[i-1];
        s_tag[i]  <= s_tag[i-1];
      end
      wb_vld_o <= s_vld[DEPTH-1];
      wb_last  <= s_last[DEPTH-1];
      wb_grp_o <= s_grp[DEPTH-1];
      wb_tag_o <= s_tag[DEPTH-1];
      // reserved at accept, released as the last group leaves execute
      if (acq_i)
        busy_o <= 1'b1;
      else if (s_vld[DEPTH-1] && s_last[DEPTH-1])
        busy_o <= 1'b0;
    end
  end

  assign ex_vld_o = s_vld[0];
  assign ex_grp_o = s_grp[0];
  assign done_o   = wb_vld_o & wb_last;
endmodule

// File: rtl/vls_dep_track.sv
module vls_dep_track
  import vls_pkg::*;
#(
  parameter int NGRP = 4,
  parameter int GW   = 2,
  parameter int CW   = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 accept_i,
  input  logic [NUM_UNITS-1:0] wb_vld_i,
  input  tag_t [NUM_UNITS-1:0] wb_tag_i,
  input  logic [GW-1:0]        chk_grp_i,
  input  logic                 chk_dep_i,
  input  logic                 chk_chain_i,
  output logic                 allow_o,
  output tag_t                 new_tag_o
);
  localparam logic [CW:0] NG_W = (CW+1)'(NGRP);

  tag_t        cur_tag, prod_tag;
  logic [CW:0] cur_cnt, prod_cnt, cur_inc, prod_inc, prod_now;

  always_comb begin
    cur_inc  = '0;
    prod_inc = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (wb_vld_i[u] && wb_tag_i[u] == cur_tag)  cur_inc  = cur_inc + 1'b1;
      if (wb_vld_i[u] && wb_tag_i[u] == prod_tag) prod_inc = prod_inc + 1'b1;
    end
  end

  // written-back count including this cycle's write-back (same-cycle chaining)
  assign prod_now  = prod_cnt + prod_inc;
  assign new_tag_o = cur_tag + 2'd1;

  always_comb begin
    if (!chk_dep_i)      allow_o = 1'b1;
    else if (chk_chain_i) allow_o = ((CW+1)'(chk_grp_i) < prod_now);
    else                  allow_o = (prod_cnt == NG_W);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_tag  <= 2'd0;
      prod_tag <= 2'd3;
      cur_cnt  <= NG_W;
      prod_cnt <= NG_W;
    end else if (accept_i) begin
      prod_tag <= cur_tag;
      prod_cnt <= cur_cnt + cur_inc;
      cur_tag  <= new_tag_o;
      cur_cnt  <= '0;
    end else begin
      cur_cnt  <= cur_cnt + cur_inc;
      prod_cnt <= prod_now;
    end
  end
endmodule

// File: rtl/vls_rd_seq.sv
module vls_rd_seq
  import vls_pkg::*;
#(
  parameter int NGRP = 4,
  parameter int GW   = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic          unit_i,
  input  logic          dep_i,
  input  logic          chain_i,
  input  tag_t          new_tag_i,
  input  logic          allow_i,
  output logic          active_o,
  output logic          fire_o,
  output logic [GW-1:0] grp_o,
  output logic          unit_o,
  output logic          dep_o,
  output logic          chain_o,
  output tag_t          tag_o,
  output logic          last_o
);
  assign fire_o = active_o & allow_i;
  assign last_o = (grp_o == GW'(NGRP-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      grp_o    <= '0;
      unit_o   <= 1'b0;
      dep_o    <= 1'b0;
      chain_o  <= 1'b0;
      tag_o    <= '0;
    end else if (accept_i) begin
      active_o <= 1'b1;
      grp_o    <= '0;
      unit_o   <= unit_i;
      dep_o    <= dep_i;
      chain_o  <= chain_i;
      tag_o    <= new_tag_i;
    end else if (fire_o) begin
      if (last_o) active_o <= 1'b0;
      else        grp_o    <= grp_o + 1'b1;
    end
  end
endmodule

// File: rtl/vlane_seq.sv
module vlane_seq
  import vls_pkg::*;
#(
  parameter int VLEN   = 32,
  parameter int LANES  = 8,
  parameter int ALU_EX = 1,
  parameter int LSU_EX = 4,
  localparam int NGRP  = VLEN / LANES,
  localparam int GW    = (NGRP > 1) ? $clog2(NGRP) : 1,
  localparam int CW    = $clog2(NGRP + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    unit_i,
  input  logic                    dep_i,
  input  logic                    chain_i,
  output logic                    ready_o,
  output logic                    rd_vld_o,
  output logic [GW-1:0]           rd_grp_o,
  output logic [NUM_UNITS-1:0]    ex_vld_o,
  output logic [NUM_UNITS*GW-1:0] ex_grp_o,
  output logic [NUM_UNITS-1:0]    wb_vld_o,
  output logic [NUM_UNITS*GW-1:0] wb_grp_o,
  output logic [NUM_UNITS-1:0]    done_o
);
  logic                 accept, allow, rd_active, rd_fire, rd_unit, rd_dep, rd_chain, rd_last;
  logic [GW-1:0]        rd_grp;
  tag_t                 rd_tag, new_tag;
  logic [NUM_UNITS-1:0] busy;
  tag_t [NUM_UNITS-1:0] wb_tag;

  assign ready_o = ~rd_active & ~busy[unit_i];
  assign accept  = start_i & ready_o;

  vls_rd_seq #(.NGRP(NGRP), .GW(GW)) u_rd (
    .clk_i, .rst_ni,
    .accept_i (accept),
    .unit_i, .dep_i, .chain_i,
    .new_tag_i(new_tag),
    .allow_i  (allow),
    .active_o (rd_active),
    .fire_o   (rd_fire),
    .grp_o    (rd_grp),
    .unit_o   (rd_unit),
    .dep_o    (rd_dep),
    .chain_o  (rd_chain),
    .tag_o    (rd_tag),
    .last_o   (rd_last)
  );

  vls_dep_track #(.NGRP(NGRP), .GW(GW), .CW(CW)) u_dep (
    .clk_i, .rst_ni,
    .accept_i   (accept),
    .wb_vld_i   (wb_vld_o),
    .wb_tag_i   (wb_tag),
    .chk_grp_i  (rd_grp),
    .chk_dep_i  (rd_dep),
    .chk_chain_i(rd_chain),
    .allow_o    (allow),
    .new_tag_o  (new_tag)
  );

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    vls_unit_pipe #(.DEPTH(unit_depth(u, ALU_EX, LSU_EX)), .GW(GW)) u_pipe (
      .clk_i, .rst_ni,
      .acq_i    (accept && (unit_i == u[0])),
      .in_vld_i (rd_fire && (rd_unit == u[0])),
      .in_grp_i (rd_grp),
      .in_tag_i (rd_tag),
      .in_last_i(rd_last),
      .ex_vld_o (ex_vld_o[u]),
      .ex_grp_o (ex_grp_o[u*GW +: GW]),
      .wb_vld_o (wb_vld_o[u]),
      .wb_grp_o (wb_grp_o[u*GW +: GW]),
      .wb_tag_o (wb_tag[u]),
      .done_o   (done_o[u]),
      .busy_o   (busy[u])
    );
  end

  assign rd_vld_o = rd_fire;
  assign rd_grp_o = rd_grp;
endmodule

// File: rtl/vlane_seq_chk.sv
module vlane_seq_chk #(
  parameter int NGRP   = 4,
  parameter int GW     = 2,
  parameter int LSU_EX = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic            ready_o,
  input logic            rd_vld_o,
  input logic [GW-1:0]   rd_grp_o,
  input logic [1:0]      ex_vld_o,
  input logic [2*GW-1:0] ex_grp_o,
  input logic [1:0]      wb_vld_o,
  input logic [2*GW-1:0] wb_grp_o,
  input logic [1:0]      done_o
);
  logic [GW-1:0] last_rd;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       last_rd <= '0;
    else if (rd_vld_o) last_rd <= rd_grp_o;
  end

  AST_RD_ASCEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_vld_o && rd_grp_o != '0 |-> rd_grp_o == last_rd + 1'b1); // R1

  AST_ALU_WB_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ex_vld_o[0] |=> wb_vld_o[0] && wb_grp_o[GW-1:0] == $past(ex_grp_o[GW-1:0])); // R2

  AST_LSU_WB_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_vld_o[1] |-> $past(ex_vld_o[1], LSU_EX)); // R3

  AST_DONE_ALU_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o[0] |-> wb_vld_o[0] && wb_grp_o[GW-1:0] == GW'(NGRP-1)); // R4

  AST_DONE_LSU_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o[1] |-> wb_vld_o[1] && wb_grp_o[2*GW-1:GW] == GW'(NGRP-1)); // R4

  AST_ACCEPT_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && ready_o |=> !ready_o); // R5
endmodule

bind vlane_seq vlane_seq_chk #(.NGRP(NGRP), .GW(GW), .LSU_EX(LSU_EX)) u_chk (
  .clk_i, .rst_ni, .start_i, .ready_o, .rd_vld_o, .rd_grp_o,
  .ex_vld_o, .ex_grp_o, .wb_vld_o, .wb_grp_o, .done_o
);

// File: tb/tb_vlane_seq.sv
module tb_vlane_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NGRP = 4;
  localparam int GW   = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, unit = 1'b0, dep = 1'b0, chain = 1'b0;
  logic ready, rd_vld;
  logic [GW-1:0] rd_grp;
  logic [1:0] ex_vld, wb_vld, done;
  logic [2*GW-1:0] ex_grp, wb_grp;

  vlane_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .unit_i(unit), .dep_i(dep),
    .chain_i(chain), .ready_o(ready), .rd_vld_o(rd_vld), .rd_grp_o(rd_grp),
    .ex_vld_o(ex_vld), .ex_grp_o(ex_grp), .wb_vld_o(wb_vld), .wb_grp_o(wb_grp),
    .done_o(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0, base = 0, nchk = 0, nfail = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic lrd[64];
  int   lrg[64];
  logic lwb[2][64];
  int   lwg[2][64];
  logic ldn[2][64];
  logic lex[2][64];
  int   lexg[2][64];

  always @(negedge clk) begin
    int i;
    i = cyc % 64;
    lrd[i] = rd_vld;
    lrg[i] = int'(rd_grp);
    for (int u = 0; u < 2; u++) begin
      lwb[u][i]  = wb_vld[u];
      lwg[u][i]  = int'(wb_grp[u*GW +: GW]);
      ldn[u][i]  = done[u];
      lex[u][i]  = ex_vld[u];
      lexg[u][i] = int'(ex_grp[u*GW +: GW]);
    end
  end

  task automatic chk(string r, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0d)", r, what, act, exp, cyc - base);
    end
  endtask

  function automatic int ix(int c);
    return (base + c) % 64;
  endfunction

  task automatic exp_rd(string r, int a, int b);
    for (int c = a; c <= b; c++) begin
      chk(r, $sformatf("rd_vld@%0d", c), int'(lrd[ix(c)]), 1);
      chk(r, $sformatf("rd_grp@%0d", c), lrg[ix(c)], c - a);
    end
  endtask

  task automatic exp_rd_none(string r, int a, int b);
    for (int c = a; c <= b; c++) chk(r, $sformatf("rd_idle@%0d", c), int'(lrd[ix(c)]), 0);
  endtask

  task automatic exp_wb(string r, int u, int a, int b);
    for (int c = a; c <= b; c++) begin
      chk(r, $sformatf("wb_vld[%0d]@%0d", u, c), int'(lwb[u][ix(c)]), 1);
      chk(r, $sformatf("wb_grp[%0d]@%0d", u, c), lwg[u][ix(c)], c - a);
    end
    chk(r, $sformatf("wb_idle[%0d]@%0d", u, a - 1), int'(lwb[u][ix(a - 1)]), 0);
    chk(r, $sformatf("wb_idle[%0d]@%0d", u, b + 1), int'(lwb[u][ix(b + 1)]), 0);
  endtask

  task automatic exp_ex(string r, int u, int a, int b);
    for (int c = a; c <= b; c++) begin
      chk(r, $sformatf("ex_vld[%0d]@%0d", u, c), int'(lex[u][ix(c)]), 1);
      chk(r, $sformatf("ex_grp[%0d]@%0d", u, c), lexg[u][ix(c)], c - a);
    end
  endtask

  task automatic exp_done(string r, int u, int at, int lo, int hi);
    for (int c = lo; c <= hi; c++)
      chk(r, $sformatf("done[%0d]@%0d", u, c), int'(ldn[u][ix(c)]), (c == at) ? 1 : 0);
  endtask

  task automatic do_reset();
    start = 1'b0; unit = 1'b0; dep = 1'b0; chain = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic go(logic u, logic d, logic ch);
    unit = u; dep = d; chain = ch; start = 1'b1;
    @(negedge clk);
    start = 1'b0; dep = 1'b0; chain = 1'b0;
  endtask

  task automatic wait_to(int c);
    while (cyc - base < c) @(negedge clk);
  endtask

  // R5: reset state, both units free, nothing moving
  task automatic t_reset();
    do_reset();
    chk("R5", "reset rd_vld", int'(rd_vld), 0);
    chk("R4", "reset wb_vld", int'(wb_vld), 0);
    chk("R4", "reset done", int'(done), 0);
    unit = 1'b0; #1;
    chk("R5", "reset ready alu", int'(ready), 1);
    unit = 1'b1; #1;
    chk("R5", "reset ready lsu", int'(ready), 1);
    unit = 1'b0;
  endtask

  // R1 R2 R4 R5: lone ALU op, reads 1..4, ex 2..5, wb 3..6, done 6
  task automatic t_alu_single();
    do_reset();
    base = cyc;
    go(1'b0, 1'b0, 1'b0);
    wait_to(5);
    unit = 1'b0; #1;
    chk("R5", "alu busy ready", int'(ready), 0);
    unit = 1'b1; #1;
    chk("R5", "lsu free ready", int'(ready), 1);
    unit = 1'b0;
    wait_to(6); #1;
    chk("R5", "alu free ready", int'(ready), 1);
    wait_to(14);
    exp_rd("R1", 1, 4);
    exp_rd_none("R1", 5, 12);
    exp_ex("R2", 0, 2, 5);
    exp_wb("R2", 0, 3, 6);
    exp_done("R4", 0, 6, 1, 12);
  endtask

  // R7 R9 R3: LSU producer then chained ALU consumer
  task automatic t_chain();
    do_reset();
    base = cyc;
    go(1'b1, 1'b0, 1'b0);
    wait_to(5);
    go(1'b0, 1'b1, 1'b1);
    wait_to(20);
    exp_rd("R1", 1, 4);
    exp_ex("R3", 1, 2, 5);
    exp_wb("R3", 1, 6, 9);
    exp_rd("R7", 6, 9);
    exp_wb("R9", 0, 8, 11);
    exp_done("R4", 1, 9, 1, 18);
    exp_done("R4", 0, 11, 1, 18);
  endtask

  // R6: same pair without chaining
  task automatic t_nochain();
    do_reset();
    base = cyc;
    go(1'b1, 1'b0, 1'b0);
    wait_to(5);
    go(1'b0, 1'b1, 1'b0);
    wait_to(22);
    exp_rd_none("R6", 5, 9);
    exp_rd("R6", 10, 13);
    exp_wb("R6", 0, 12, 15);
    exp_done("R6", 0, 15, 1, 20);
  endtask

  // R8: independent op with chaining off is not held
  task automatic t_nodep();
    do_reset();
    base = cyc;
    go(1'b1, 1'b0, 1'b0);
    wait_to(5);
    go(1'b0, 1'b0, 1'b0);
    wait_to(20);
    exp_rd("R8", 6, 9);
    exp_wb("R8", 0, 8, 11);
  endtask

  // R5: start while the unit is busy is ignored
  task automatic t_busy();
    do_reset();
    base = cyc;
    go(1'b1, 1'b0, 1'b0);
    wait_to(5);
    unit = 1'b1; start = 1'b1; #1;
    chk("R5", "lsu busy ready", int'(ready), 0);
    @(negedge clk);
    start = 1'b0;
    wait_to(8); #1;
    chk("R5", "lsu busy ready late", int'(ready), 0);
    wait_to(9); #1;
    chk("R5", "lsu released ready", int'(ready), 1);
    wait_to(18);
    exp_rd_none("R5", 5, 16);
    exp_done("R5", 1, 9, 1, 16);
  endtask

  bit finished = 1'b0;

  initial begin
    t_reset();
    t_alu_single();
    t_chain();
    t_nochain();
    t_nodep();
    t_busy();
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule